// File: doc/BRIEF.md
# Bidirectional Bus Turnaround Sequencer

This block sits between a bus master and the two halves of a set of bidirectional data pads. It decides, one clock at a time, which side may drive the shared lines, so that two drivers are never on at once. The master signals that it wants to write by pulling an active-low drive request. The sequencer then first turns off the input half-pad. Next it turns on the output half-pad. Only after that does it hand the master a feedback enable for its own internal data lines. When the request is withdrawn, the same steps run in reverse order.

An external arbiter can take the bus at any time with an active-high disable input. That input turns off the output half-pad and the master's feedback enable at once, without waiting for a clock. Once the disable is released, the output drive is never switched back on directly. The sequencer restarts from the break step that matches the current request.

The data paths are plain multiplexers and are never retimed. The pad output always carries the master's write data. The master's internal bus sees its own data while it drives, sees the pad data in input mode, and sees zero while the bus is between directions. The master's bus-enable and tristate-enable inputs are tied inactive-high.

Top module: `bus_turn_seq`

States: ST_IN (input mode, idle), ST_BRK_IN (gap before output), ST_OUT (output pad on, master not yet driving), ST_DRV (master driving), ST_BRK_OUT (gap before input), ST_LOCK (held off by the external disable). Transitions:

- ST_IN to ST_BRK_IN when the request is low and the disable is low.
- ST_BRK_IN to ST_OUT when the request stays low, to ST_IN when it is withdrawn, and to ST_LOCK when the disable is set.
- ST_OUT to ST_DRV when the request is held. ST_OUT and ST_DRV both go to ST_BRK_OUT when the request rises, and to ST_LOCK when the disable is set.
- ST_BRK_OUT always goes to ST_IN.
- ST_LOCK stays while the disable is set. Otherwise it goes to ST_BRK_IN when the request is low, or to ST_BRK_OUT when it is high.

## Requirements
- R1: A synchronous active-low reset, sampled at a clock edge, puts the block in input mode: in_en_n=0, out_en_n=1, fb_en_n=1. The reset takes effect whatever the other inputs are.
- R2: Turn from input to output, starting in input mode. If drv_req_n=0 and ext_off=0 are sampled at edge k, in_en_n goes to 1 after edge k. out_en_n goes to 0 after edge k+1, and fb_en_n goes to 0 after edge k+2, as long as the request is held.
- R3: At no sampled clock edge are in_en_n and out_en_n both 0.
- R4: fb_en_n is 0 only while out_en_n is 0 and drv_req_n is 0.
- R5: Turn from output to input. When drv_req_n rises while the master drives, fb_en_n goes to 1 in the same cycle, with no clock. out_en_n goes to 1 after the next edge, and in_en_n goes to 0 one edge after that.
- R6: While ext_off=1, out_en_n=1 and fb_en_n=1 in every state, combinationally.
- R7: After ext_off clears, output drive restarts through a break step. With the request low, out_en_n stays 1 for the first edge and goes to 0 after the second. With the request high, the block passes through both-off and then returns to input mode.
- R8: In input mode with ext_off=1, a low request is held off. The block stays in input mode (in_en_n=0) until ext_off clears.
- R9: mst_bus_en and mst_tri_en are always 1.
- R10: pad_dout always equals core_dout, in every state. core_din equals core_dout while fb_en_n=0, equals pad_din while in_en_n=0, and is 0 otherwise.
- R11: If the request is withdrawn mid-turn, the block returns safely. From the gap before output it is back in input mode after the next edge. With only the output pad on, out_en_n goes to 1 after the next edge and in_en_n goes to 0 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| drv_req_n | input | 1 | Master drive request, active low |
| ext_off | input | 1 | External bus disable, active high, acts asynchronously on the output side |
| core_dout | input | DW | Master write data |
| pad_din | input | DW | Data arriving from the pads |
| in_en_n | output | 1 | Input half-pad enable, active low |
| out_en_n | output | 1 | Output half-pad enable, active low |
| fb_en_n | output | 1 | Feedback drive enable to the master, active low |
| core_din | output | DW | Value on the master's internal data bus |
| pad_dout | output | DW | Data presented to the output half-pad |
| mst_bus_en | output | 1 | Master internal bus enable, tied inactive-high |
| mst_tri_en | output | 1 | Master tristate enable, tied inactive-high |

## Verification
The hardest cases to reach from the ports are the external disable striking in the middle of a turn and the restart that follows its release. Another is a request withdrawn while the bus sits in one of the gap states. The stimulus table walks into ST_OUT and ST_DRV, sets the disable there, and releases it once with the request still low and once with it high. It also withdraws requests from ST_BRK_IN and ST_OUT. Directed steps then change the request and the disable between clock edges, to show that the feedback and output enables drop without waiting for a clock.

// File: rtl/bts_pkg.sv
package bts_pkg;
    typedef enum logic [2:0] {
        ST_IN      = 3'd0,
        ST_BRK_IN  = 3'd1,
        ST_OUT     = 3'd2,
        ST_DRV     = 3'd3,
        ST_BRK_OUT = 3'd4,
        ST_LOCK    = 3'd5
    } bts_state_e;
endpackage

// File: rtl/bts_fsm.sv
module bts_fsm
    import bts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       drv_req_n,
    input  logic       ext_off,
    output bts_state_e state
);
    bts_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IN:      if (!drv_req_n && !ext_off) nxt = ST_BRK_IN;
            ST_BRK_IN:  if (ext_off)        nxt = ST_LOCK;
                        else if (drv_req_n) nxt = ST_IN;
                        else                nxt = ST_OUT;
            ST_OUT:     if (ext_off)        nxt = ST_LOCK;
                        else if (drv_req_n) nxt = ST_BRK_OUT;
                        else                nxt = ST_DRV;
            ST_DRV:     if (ext_off)        nxt = ST_LOCK;
                        else if (drv_req_n) nxt = ST_BRK_OUT;
            ST_BRK_OUT: nxt = ST_IN;
            ST_LOCK:    if (ext_off)        nxt = ST_LOCK;
                        else if (drv_req_n) nxt = ST_BRK_OUT;
                        else                nxt = ST_BRK_IN;
            default:    nxt = ST_IN;
        endcase
    end
endmodule

// File: rtl/bts_outdec.sv
module bts_outdec
    import bts_pkg::*;
(
    input  bts_state_e state,
    input  logic       drv_req_n,
    input  logic       ext_off,
    output logic       in_en_n,
    output logic       out_en_n,
    output logic       fb_en_n
);
    always_comb begin
        in_en_n  = 1'b1;
        out_en_n = 1'b1;
        fb_en_n  = 1'b1;
        unique case (state)
            ST_IN:      in_en_n = 1'b0;
            ST_BRK_IN:  ;
            ST_OUT:     out_en_n = ext_off;
            ST_DRV: begin
                out_en_n = ext_off;
                fb_en_n  = ext_off | drv_req_n;
            end
            ST_BRK_OUT: ;
            ST_LOCK:    ;
            default:    ;
        endcase
    end
endmodule

// File: rtl/bts_datapath.sv
module bts_datapath #(
    parameter int DW = 32
) (
    input  logic          in_en_n,
    input  logic          fb_en_n,
    input  logic [DW-1:0] core_dout,
    input  logic [DW-1:0] pad_din,
    output logic [DW-1:0] core_din,
    output logic [DW-1:0] pad_dout
);
    assign pad_dout = core_dout;

    always_comb begin
        if (!fb_en_n)      core_din = core_dout;
        else if (!in_en_n) core_din = pad_din;
        else               core_din = '0;
    end
endmodule

// File: rtl/bus_turn_seq.sv
module bus_turn_seq #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drv_req_n,
    input  logic          ext_off,
    input  logic [DW-1:0] core_dout,
    input  logic [DW-1:0] pad_din,
    output logic          in_en_n,
    output logic          out_en_n,
    output logic          fb_en_n,
    output logic [DW-1:0] core_din,
    output logic [DW-1:0] pad_dout,
    output logic          mst_bus_en,
    output logic          mst_tri_en
);
    import bts_pkg::*;

    bts_state_e state;

    bts_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .drv_req_n (drv_req_n),
        .ext_off   (ext_off),
        .state     (state)
    );

    bts_outdec u_dec (
        .state     (state),
        .drv_req_n (drv_req_n),
        .ext_off   (ext_off),
        .in_en_n   (in_en_n),
        .out_en_n  (out_en_n),
        .fb_en_n   (fb_en_n)
    );

    bts_datapath #(.DW(DW)) u_dp (
        .in_en_n   (in_en_n),
        .fb_en_n   (fb_en_n),
        .core_dout (core_dout),
        .pad_din   (pad_din),
        .core_din  (core_din),
        .pad_dout  (pad_dout)
    );

    // R9: master internal bus and tristate enables held inactive-high
    assign mst_bus_en = 1'b1;
    assign mst_tri_en = 1'b1;
endmodule

// File: rtl/bus_turn_seq_chk.sv
module bus_turn_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic drv_req_n,
    input logic ext_off,
    input logic in_en_n,
    input logic out_en_n,
    input logic fb_en_n
);
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!in_en_n && !out_en_n));

    p_fb_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_en_n |-> (!out_en_n && !drv_req_n));

    p_ext_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_off |-> (out_en_n && fb_en_n));

    p_make_after_break_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_en_n) |-> ($past(in_en_n) && $past(out_en_n)));

    p_in_after_break_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_en_n) |-> ($past(out_en_n) && $past(in_en_n)));

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en_n && drv_req_n && !ext_off) |=> out_en_n);
endmodule

bind bus_turn_seq bus_turn_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_req_n (drv_req_n),
    .ext_off   (ext_off),
    .in_en_n   (in_en_n),
    .out_en_n  (out_en_n),
    .fb_en_n   (fb_en_n)
);

// File: tb/test_bus_turn_seq.sv
module test_bus_turn_seq;
    localparam int DW = 32;
    localparam time CLK_P = 4ns;
    localparam int NV = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_req_n = 1'b1;
    logic ext_off = 1'b0;
    logic [DW-1:0] core_dout = '0;
    logic [DW-1:0] pad_din = '0;
    logic in_en_n, out_en_n, fb_en_n, mst_bus_en, mst_tri_en;
    logic [DW-1:0] core_din, pad_dout;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bus_turn_seq #(.DW(DW)) i_bus_turn_seq (
        .clk(clk), .rst_n(rst_n), .drv_req_n(drv_req_n), .ext_off(ext_off),
        .core_dout(core_dout), .pad_din(pad_din),
        .in_en_n(in_en_n), .out_en_n(out_en_n), .fb_en_n(fb_en_n),
        .core_din(core_din), .pad_dout(pad_dout),
        .mst_bus_en(mst_bus_en), .mst_tri_en(mst_tri_en)
    );

    // {rst_n, drv_req_n, ext_off, exp in_en_n, exp out_en_n, exp fb_en_n}
    localparam logic [5:0] VEC [NV] = '{
        6'b010_011, // 0  R1 reset
        6'b110_011, // 1  idle
        6'b100_111, // 2  R2 break before output
        6'b100_101, // 3  R2 output pad on
        6'b100_100, // 4  R2 master drives
        6'b100_100, // 5  held
        6'b110_111, // 6  R5 output released
        6'b110_011, // 7  R5 input back
        6'b101_011, // 8  R8 disable holds input mode
        6'b100_111, // 9  R8 request resumes after release
        6'b100_101, // 10 output pad on
        6'b101_111, // 11 R6 disable in output state
        6'b101_111, // 12 locked
        6'b100_111, // 13 R7 break step after release
        6'b100_101, // 14 R7 output again
        6'b100_100, // 15 drive
        6'b101_111, // 16 R6 disable in drive state
        6'b110_111, // 17 R7 release with request high
        6'b110_011, // 18 R7 input mode
        6'b100_111, // 19 break
        6'b110_011, // 20 R11 withdraw from gap
        6'b100_111, // 21 break
        6'b100_101, // 22 output pad on
        6'b110_111, // 23 R11 withdraw with pad on
        6'b110_011, // 24 R11 input mode
        6'b100_111, // 25 break
        6'b000_011, // 26 R1 reset mid-turn
        6'b110_011  // 27 idle
    };

    localparam int TAG [NV] = '{1,1,2,2,2,2,5,5,8,8,2,6,6,7,7,2,6,7,7,2,11,2,2,11,11,2,1,1};

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    task automatic step(input logic r, input logic q, input logic e);
        @(negedge clk);
        rst_n = r; drv_req_n = q; ext_off = e;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NV; i++) begin
            string rq;
            logic [DW-1:0] exp_din;
            logic [5:0] v;
            v = VEC[i];
            @(negedge clk);
            rst_n = v[5]; drv_req_n = v[4]; ext_off = v[3];
            core_dout = 32'hC0DE_0000 | i;
            pad_din   = 32'hFA00_0000 | i;
            @(posedge clk);
            #1;
            rq = $sformatf("R%0d row%0d", TAG[i], i);
            chk(in_en_n  == v[2], rq, {31'd0, in_en_n},  {31'd0, v[2]});
            chk(out_en_n == v[1], rq, {31'd0, out_en_n}, {31'd0, v[1]});
            chk(fb_en_n  == v[0], rq, {31'd0, fb_en_n},  {31'd0, v[0]});
            // R3 exclusive pad enables every step
            chk(!(!in_en_n && !out_en_n), "R3", {30'd0, in_en_n, out_en_n}, 32'd1);
            // R10 data muxing
            exp_din = !v[0] ? core_dout : (!v[2] ? pad_din : '0);
            chk(core_din == exp_din, "R10 core_din", core_din, exp_din);
            chk(pad_dout == core_dout, "R10 pad_dout", pad_dout, core_dout);
            // R9 tie-offs
            chk(mst_bus_en && mst_tri_en, "R9", {30'd0, mst_bus_en, mst_tri_en}, 32'd3);
            // R4 feedback only with pad on and request low
            chk(fb_en_n || (!out_en_n && !drv_req_n), "R4", {31'd0, fb_en_n}, 32'd1);
        end

        // R5: feedback drops without a clock when the request rises
        step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
        chk(fb_en_n == 1'b0, "R2 drive reached", {31'd0, fb_en_n}, 32'd0);
        @(negedge clk);
        drv_req_n = 1'b1;
        #1;
        chk(fb_en_n == 1'b1, "R5 immediate stop", {31'd0, fb_en_n}, 32'd1);
        chk(out_en_n == 1'b0, "R5 pad still on", {31'd0, out_en_n}, 32'd0);
        @(posedge clk); #1;
        chk(out_en_n == 1'b1 && in_en_n == 1'b1, "R5 gap", {30'd0, in_en_n, out_en_n}, 32'd3);
        @(posedge clk); #1;
        chk(in_en_n == 1'b0, "R5 input back", {31'd0, in_en_n}, 32'd0);

        // R6: disable acts between clock edges
        step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
        @(negedge clk);
        ext_off = 1'b1;
        #1;
        chk(out_en_n == 1'b1, "R6 async out", {31'd0, out_en_n}, 32'd1);
        chk(fb_en_n == 1'b1, "R6 async fb", {31'd0, fb_en_n}, 32'd1);
        chk(core_din == '0, "R10 gap data", core_din, '0);
        step(1, 0, 0);
        chk(out_en_n == 1'b1, "R7 no direct reassert", {31'd0, out_en_n}, 32'd1);
        step(1, 0, 0);
        chk(out_en_n == 1'b0, "R7 reassert via break", {31'd0, out_en_n}, 32'd0);
        step(1, 1, 0); step(1, 1, 0);
        chk(in_en_n == 1'b0, "R5 settle", {31'd0, in_en_n}, 32'd0);

        finish_run();
    end
endmodule